// File: doc/BRIEF.md
# LCD Segment Pixel Mapper

This block produces the segment drive word for a dot-matrix LCD one common line at a time. Each crossing of one of 64 segments and one of up to 8 common lines has two programmable entries. The first names a byte of the display data memory. The second picks a bit inside that byte. The picked bit becomes the pixel value for that crossing. When this indirection is switched off, or when the scan conditions forbid it, a fixed map applies instead.

A byte-wide bus port gives write and registered read access to the display data memory, the byte-address table, the bit-index table, a mode register and a duty register. A scan engine walks the segments of the current common line at one per clock. After the last segment it presents the finished 64-bit word with a one-cycle strobe and the index of its common line. It then moves to the next common line, and wraps to line 0 once the programmed duty count is reached. Bias generation and analog waveforms lie outside this block.

Top module: `lcdPixelMapper`

## Requirements
- R1: After reset, `segValid`, `segOut` and `busRdata` are 0, and the mode register (F100h) and duty register (F101h) read back as 0.
- R2: A write with `busWe` stores `busWdata` at `busAddr`. A read with `busRe` puts the stored value on `busRdata` one clock later. The address map is: display bytes 00h..FEh at F000h..F0FEh, mode at F100h, duty code at F101h, byte-address table at F400h..F5FFh, bit-index table at F600h..F7FFh. The table entry offset is common*64 + segment.
- R3: In a bit-index entry, writes to bits 7..3 are dropped, and those bits always read back as 0.
- R4: The scan takes one segment per clock. `segValid` pulses for one cycle every 64 cycles. `comOut` counts up by one per pulse and wraps to 0 after reaching (duty code + 1) - 1.
- R5: While the indirection is inactive, the pixel for segment s on common c is bit (c mod 8) of display byte (c div 8)*64 + s. For c < 8 this is bit c of byte s.
- R6: While the indirection is active, the pixel for segment s on common c is the bit named by bit-index entry c*64+s, taken from the display byte named by byte-address entry c*64+s. Segment s appears at `segOut[s]`.
- R7: The indirection is active only if mode bit 0 (enable) is 1 and mode bits 2..1 (map type) equal 3.
- R8: With a common count above 8 (duty code 8 or more), the indirection stays inactive whatever the mode register holds.
- R9: Mode bits 4..3 select the frame rate (0: ~64 Hz, 1: ~73 Hz, 2: ~85 Hz, 3: ~102 Hz). The indirection is active only if the common count is at most 8, 7, 6 or 5 respectively.
- R10: A pixel whose byte address is FFh is 0. A write to F0FFh is dropped, and a read of F0FFh returns 0.
- R11: Duty codes above 23 are stored as 23, so at most 24 common lines are scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | Bus byte address |
| busWdata | input | 8 | Bus write data |
| busWe | input | 1 | Bus write enable |
| busRe | input | 1 | Bus read enable, data valid the next cycle |
| busRdata | output | 8 | Registered read data |
| segOut | output | 64 | Resolved segment word of the last finished line |
| segValid | output | 1 | One-cycle strobe when `segOut` is updated |
| comOut | output | 5 | Common line index of `segOut` |

## Verification
The display memory is filled with an arithmetic byte pattern. The two tables are filled with address and bit patterns that differ from the fixed map, and a few address entries are FFh. Every resolved line is then compared against a word computed in the bench. The fixed map and the indirect map give clearly different words under these patterns, so each gating case shows which path was taken. The cases are: enable off, wrong map type, duty 9, a frame rate whose limit is exceeded, and a count exactly at that limit. The pulse spacing and the common line sequence are also checked at duty counts of 3, 5, 8, 9 and 24.

// File: rtl/lcdMapPkg.sv
package lcdMapPkg;
  localparam int NUM_SEG  = 64;
  localparam int SEG_W    = $clog2(NUM_SEG);
  localparam int MAX_COM  = 8;
  localparam int MAX_DUTY = 24;
  localparam int COM_W    = $clog2(MAX_DUTY);

  typedef struct packed {
    logic [SEG_W-1:0] segIdx;
    logic [COM_W-1:0] comIdx;
    logic             lastSeg;
  } scanCmd_t;
endpackage

// File: rtl/lcdScanCtrl.sv
module lcdScanCtrl
  import lcdMapPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [COM_W-1:0] comCount,
  output scanCmd_t         cmd
);
  logic [SEG_W-1:0] segIdx;
  logic [COM_W-1:0] comIdx;
  logic             lastSeg;

  assign lastSeg = (segIdx == SEG_W'(NUM_SEG - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segIdx <= '0;
      comIdx <= '0;
    end else begin
      segIdx <= segIdx + 1'b1;
      if (lastSeg) begin
        if ((comIdx + 1'b1) >= comCount) comIdx <= '0;
        else                             comIdx <= comIdx + 1'b1;
      end
    end
  end

  assign cmd = '{segIdx: segIdx, comIdx: comIdx, lastSeg: lastSeg};

  // R4
  segStep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lastSeg |=> segIdx == $past(segIdx) + 1'b1);
  // R4
  segWrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastSeg |=> segIdx == '0);
  // R11
  comRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    comIdx < COM_W'(MAX_DUTY));
endmodule

// File: rtl/lcdMapDatapath.sv
module lcdMapDatapath
  import lcdMapPkg::*;
#(
  parameter logic [15:0] DISP_BASE = 16'hF000,
  parameter logic [15:0] MODE_ADDR = 16'hF100,
  parameter logic [15:0] DUTY_ADDR = 16'hF101,
  parameter logic [15:0] ATAB_BASE = 16'hF400,
  parameter logic [15:0] BTAB_BASE = 16'hF600
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        busAddr,
  input  logic [7:0]         busWdata,
  input  logic               busWe,
  input  logic               busRe,
  output logic [7:0]         busRdata,
  input  scanCmd_t           cmd,
  output logic [COM_W-1:0]   comCount,
  output logic [NUM_SEG-1:0] segOut,
  output logic               segValid,
  output logic [COM_W-1:0]   comOut
);
  localparam int POINTS     = NUM_SEG * MAX_COM;
  localparam int PT_W       = $clog2(POINTS);
  localparam int DISP_BYTES = 255;
  localparam int CSEL_W     = $clog2(MAX_COM);

  logic [7:0] dispMem [DISP_BYTES];
  logic [7:0] addrTab [POINTS];
  logic [2:0] bitTab  [POINTS];

  logic             mapEn;
  logic [1:0]       mapType;
  logic [1:0]       frameSel;
  logic [COM_W-1:0] dutyCode;

  // bus decode
  logic inDisp, inMode, inDuty, inAtab, inBtab;
  logic [PT_W-1:0] busPt;
  assign inDisp = (busAddr[15:8] == DISP_BASE[15:8]) && (busAddr[7:0] != 8'hFF);
  assign inMode = (busAddr == MODE_ADDR);
  assign inDuty = (busAddr == DUTY_ADDR);
  assign inAtab = (busAddr[15:PT_W] == ATAB_BASE[15:PT_W]);
  assign inBtab = (busAddr[15:PT_W] == BTAB_BASE[15:PT_W]);
  assign busPt  = busAddr[PT_W-1:0];

  always_ff @(posedge clk) begin
    if (busWe && inDisp) dispMem[busAddr[7:0]] <= busWdata;
    if (busWe && inAtab) addrTab[busPt] <= busWdata;
    if (busWe && inBtab) bitTab[busPt]  <= busWdata[2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapEn    <= 1'b0;
      mapType  <= '0;
      frameSel <= '0;
      dutyCode <= '0;
    end else if (busWe) begin
      if (inMode) begin
        mapEn    <= busWdata[0];
        mapType  <= busWdata[2:1];
        frameSel <= busWdata[4:3];
      end
      if (inDuty)
        dutyCode <= (busWdata > 8'(MAX_DUTY - 1)) ? COM_W'(MAX_DUTY - 1) : busWdata[COM_W-1:0];
    end
  end

  logic [7:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (inDisp)      rdNext = dispMem[busAddr[7:0]];
    else if (inMode) rdNext = {3'b000, frameSel, mapType, mapEn};
    else if (inDuty) rdNext = 8'(dutyCode);
    else if (inAtab) rdNext = addrTab[busPt];
    else if (inBtab) rdNext = {5'b00000, bitTab[busPt]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRe) busRdata <= rdNext;
  end

  // mapping gate: enable, map type 3, common count within frame-rate limit
  logic [COM_W-1:0] comLimit;
  logic             mapActive;
  assign comCount  = dutyCode + 1'b1;
  assign comLimit  = COM_W'(MAX_COM) - COM_W'(frameSel);
  assign mapActive = mapEn && (mapType == 2'd3) && (comCount <= comLimit);

  // pixel resolution for the current scan point
  logic [PT_W-1:0] ptIdx;
  logic [7:0]      pixAddr;
  logic [2:0]      pixBit;
  logic [7:0]      pixByte;
  logic            pixel;
  assign ptIdx = {cmd.comIdx[CSEL_W-1:0], cmd.segIdx};

  always_comb begin
    if (mapActive) begin
      pixAddr = addrTab[ptIdx];
      pixBit  = bitTab[ptIdx];
    end else begin
      pixAddr = 8'({cmd.comIdx[COM_W-1:CSEL_W], cmd.segIdx});
      pixBit  = cmd.comIdx[CSEL_W-1:0];
    end
    pixByte = (pixAddr == 8'hFF) ? 8'h00 : dispMem[pixAddr];
    pixel   = pixByte[pixBit];
  end

  logic [NUM_SEG-1:0] lineBuf;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineBuf  <= '0;
      segOut   <= '0;
      segValid <= 1'b0;
      comOut   <= '0;
    end else begin
      lineBuf[cmd.segIdx] <= pixel;
      segValid <= cmd.lastSeg;
      if (cmd.lastSeg) begin
        segOut <= {pixel, lineBuf[NUM_SEG-2:0]};
        comOut <= cmd.comIdx;
      end
    end
  end

  // R4
  validPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid |=> !segValid);
  // R4
  strobeAfterLast_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lastSeg |=> segValid);
  // R3
  bitReadZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && inBtab) |=> busRdata[7:3] == 5'b00000);
  // R11
  dutyClamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    dutyCode <= COM_W'(MAX_DUTY - 1));
endmodule

// File: rtl/lcdPixelMapper.sv
module lcdPixelMapper
  import lcdMapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busWdata,
  input  logic        busWe,
  input  logic        busRe,
  output logic [7:0]  busRdata,
  output logic [63:0] segOut,
  output logic        segValid,
  output logic [4:0]  comOut
);
  scanCmd_t         cmd;
  logic [COM_W-1:0] comCount;

  lcdScanCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .comCount(comCount), .cmd(cmd)
  );

  lcdMapDatapath u_dp (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .cmd(cmd), .comCount(comCount),
    .segOut(segOut), .segValid(segValid), .comOut(comOut)
  );
endmodule

// File: tb/lcdPixelMapper_bench.sv
module lcdPixelMapper_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busRdata;
  logic [63:0] segOut;
  logic        segValid;
  logic [4:0]  comOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  lcdPixelMapper u_lcdPixelMapper (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .segOut(segOut), .segValid(segValid), .comOut(comOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] dispVal(int b);
    return 8'((b * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] addrVal(int i);
    return 8'((i * 7 + 3) % 256);
  endfunction
  function automatic logic [2:0] bitVal(int i);
    return 3'((i * 3 + i / 64) % 8);
  endfunction

  function automatic logic [63:0] expWord(int c, bit mapped);
    logic [63:0] w;
    for (int s = 0; s < 64; s++) begin
      int a;
      int b;
      logic [7:0] d;
      if (mapped) begin
        a = addrVal(c * 64 + s);
        b = bitVal(c * 64 + s);
      end else begin
        a = (c / 8) * 64 + s;
        b = c % 8;
      end
      d = (a == 255) ? 8'h00 : dispVal(a);
      w[s] = d[b];
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!segValid);
  endtask

  // configure, flush two lines, then check n lines
  task automatic runLines(int n, logic [7:0] mode, int dutyCnt, bit mapped, string req);
    int prevCom;
    int prevCyc;
    busWrite(16'hF100, mode);
    busWrite(16'hF101, 8'(dutyCnt - 1));
    waitStrobe();
    waitStrobe();
    prevCom = comOut;
    prevCyc = cyc;
    for (int k = 0; k < n; k++) begin
      int expCom;
      waitStrobe();
      expCom = (prevCom + 1 >= dutyCnt) ? 0 : prevCom + 1;
      chk(comOut == 5'(expCom), {req, " R4 com"}, 64'(comOut), 64'(expCom));
      chk(cyc - prevCyc == 64, "R4 period", 64'(cyc - prevCyc), 64'd64);
      chk(segOut == expWord(comOut, mapped), req, segOut, expWord(comOut, mapped));
      prevCom = comOut;
      prevCyc = cyc;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1
    chk(segValid == 1'b0, "R1 segValid", 64'(segValid), 64'd0);
    chk(segOut == '0, "R1 segOut", segOut, 64'd0);
    chk(busRdata == '0, "R1 busRdata", 64'(busRdata), 64'd0);
    rstN = 1'b1;
    busRead(16'hF100, rd);
    chk(rd == 8'h00, "R1 mode", 64'(rd), 64'd0);
    busRead(16'hF101, rd);
    chk(rd == 8'h00, "R1 duty", 64'(rd), 64'd0);

    // R2 fill memories
    for (int b = 0; b < 255; b++) busWrite(16'hF000 + 16'(b), dispVal(b));
    busWrite(16'hF0FF, 8'hA5);
    for (int i = 0; i < 512; i++) busWrite(16'hF400 + 16'(i), addrVal(i));
    for (int i = 0; i < 512; i++) busWrite(16'hF600 + 16'(i), {5'b11111, bitVal(i)});

    for (int b = 0; b < 255; b += 17) begin
      busRead(16'hF000 + 16'(b), rd);
      chk(rd == dispVal(b), "R2 display readback", 64'(rd), 64'(dispVal(b)));
    end
    busRead(16'hF0FF, rd);
    chk(rd == 8'h00, "R10 F0FF reads zero", 64'(rd), 64'd0);
    for (int i = 0; i < 512; i += 37) begin
      busRead(16'hF400 + 16'(i), rd);
      chk(rd == addrVal(i), "R2 address table readback", 64'(rd), 64'(addrVal(i)));
      busRead(16'hF600 + 16'(i), rd);
      chk(rd == {5'b0, bitVal(i)}, "R3 bit table readback", 64'(rd), 64'(bitVal(i)));
    end

    // R5 fallback with mapping disabled, duty 3
    runLines(6, 8'h00, 3, 1'b0, "R5 fallback");
    // R6 / R10 mapping active at duty 8, frame sel 0 (entries 36 and 292 are FFh)
    runLines(10, 8'h07, 8, 1'b1, "R6 R10 mapped");
    // R7 enable set but map type 2
    runLines(4, 8'h05, 8, 1'b0, "R7 type not 3");
    // R7 map type 3 but enable clear
    runLines(4, 8'h06, 8, 1'b0, "R7 enable clear");
    // R8 duty 9 forces fallback, covers common 8
    runLines(10, 8'h07, 9, 1'b0, "R8 duty 9");
    // R9 frame sel 3 limit 5: count 6 inactive, count 5 active
    runLines(7, 8'h1F, 6, 1'b0, "R9 over limit");
    runLines(6, 8'h1F, 5, 1'b1, "R9 at limit");
    // R9 frame sel 1 limit 7: count 7 active
    runLines(7, 8'h0F, 7, 1'b1, "R9 sel1 at limit");

    // R11 duty clamp
    busWrite(16'hF101, 8'd31);
    busRead(16'hF101, rd);
    chk(rd == 8'd23, "R11 duty clamp", 64'(rd), 64'd23);
    runLines(26, 8'h00, 24, 1'b0, "R11 R5 duty 24");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule